// File: doc/BRIEF.md
# Byte-Serial Pixel Coprocessor Command Engine

This block is a small coprocessor that a host controls through one byte-wide port with separate write and read strobes. The first byte the host writes is an opcode. The engine then collects that opcode's parameter bytes into a parameter store, runs the operation over several clock cycles, and fills a result store. The host drains the result store one byte per read strobe.

Four operations produce or change state here. One sets a transparent colour key. One overlays two 4-bit-per-pixel bitmaps nibble by nibble, using that key. One reverses a 4bpp bitmap row. One multiplies two unsigned 16-bit operands. Other opcodes are still parsed so that the byte stream stays aligned, but their work is done by other blocks. The overlay and the reverse operations take a length byte first, and that byte re-arms the parameter counter for the bitmap bytes that follow.

While an operation runs, `busy` is high. Reads return 0xFF and do not advance, and writes are dropped.

Top module: `gfx_cmd_engine`

## Requirements
- R1: After synchronous reset, `busy` is 0, a read returns 0xFF, the next written byte is taken as an opcode, and the transparent key is 0.
- R2: The parameter bytes expected after each opcode are: 0x01 → 32, 0x03 → 1, 0x05 → 1, 0x06 → 1, 0x09 → 4, 0x0D → 2. Opcodes 0x07, 0x08, 0x0F and every other value expect 0. The byte after the last parameter is again an opcode. Opcodes 0x01, 0x0D, 0x07, 0x08 and 0x0F produce no result bytes.
- R3: Opcode 0x03 takes one byte, and that byte's low nibble (bits 3:0) becomes the transparent key.
- R4: Opcode 0x05 takes a length L (1..255) and then 2·L bytes: first bitmap A, then bitmap B. It yields L bytes. Each nibble of result byte i is the nibble of A[i] when the matching nibble of B[i] equals the key, and the nibble of B[i] otherwise.
- R5: Opcode 0x06 takes a length L (1..255) and then L bytes. It yields L bytes, where result byte i is input byte L-1-i with its high and low nibbles exchanged.
- R6: A length byte of 0 after opcode 0x05 or 0x06 returns the engine at once to waiting for an opcode, and no result is produced.
- R7: Opcode 0x09 takes four bytes: a low byte, a high byte, b low byte, b high byte. It yields the unsigned 32-bit product a·b as four bytes, least significant first.
- R8: A read with no result pending returns 0xFF. Each read of a pending result returns the next byte. Once the last byte has been read, later reads return 0xFF.
- R9: While `busy` is high, reads return 0xFF and do not advance the read position, and writes are ignored.
- R10: Each time the parameter count of a phase is reached, the read position returns to the first result byte. This holds even for an opcode that produces no new result, in which case the earlier result becomes readable again from its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Opcode or parameter byte |
| rd_en | input | 1 | Read strobe, consumes the byte on rd_data |
| rd_data | output | 8 | Current result byte, or 0xFF when nothing is readable |
| busy | output | 1 | High while an operation fills the result store |

## Verification
A parameter counter that is off by one leaves the engine misaligned with the host. A later parameter byte is then taken as an opcode, and the next result read shows a wrong byte or 0xFF where data was expected, so the fault appears on the first read after the mistaken command. A stuck length-pending flag turns the next overlay or reverse into a single-byte command, which appears as 0xFF on its first read. A read position that is wrong or not reset shows up as a rotated or repeated byte sequence at `rd_data`. A busy window that is too short shows up as stale result bytes on the very first read after launch.

// File: rtl/gfx_cmd_pkg.sv
package gfx_cmd_pkg;

    localparam int BUF_DEPTH = 512;
    localparam int IDX_W     = $clog2(BUF_DEPTH);

    localparam logic [7:0] OP_TILE  = 8'h01;
    localparam logic [7:0] OP_KEY   = 8'h03;
    localparam logic [7:0] OP_OVL   = 8'h05;
    localparam logic [7:0] OP_REV   = 8'h06;
    localparam logic [7:0] OP_MUL   = 8'h09;
    localparam logic [7:0] OP_SCALE = 8'h0D;

    typedef enum logic [1:0] {
        EX_OVERLAY = 2'd0,
        EX_REVERSE = 2'd1,
        EX_PRODUCT = 2'd2
    } exec_kind_e;

    typedef enum logic {
        SQ_CMD   = 1'b0,
        SQ_PARAM = 1'b1
    } seq_state_e;

    typedef struct packed {
        exec_kind_e        kind;
        logic [IDX_W-1:0]  len;
        logic [31:0]       opnd;
    } launch_t;

    // parameter bytes expected directly after an opcode
    function automatic logic [IDX_W-1:0] param_count(input logic [7:0] op);
        case (op)
            OP_TILE:               return IDX_W'(32);
            OP_KEY, OP_OVL, OP_REV: return IDX_W'(1);
            OP_MUL:                return IDX_W'(4);
            OP_SCALE:              return IDX_W'(2);
            default:               return '0;
        endcase
    endfunction

    function automatic logic [7:0] key_merge(input logic [7:0] a, input logic [7:0] b,
                                             input logic [3:0] key);
        logic [7:0] r;
        r[7:4] = (b[7:4] == key) ? a[7:4] : b[7:4];
        r[3:0] = (b[3:0] == key) ? a[3:0] : b[3:0];
        return r;
    endfunction

    function automatic logic [7:0] nib_swap(input logic [7:0] v);
        return {v[3:0], v[7:4]};
    endfunction

endpackage

// File: rtl/gfx_param_seq.sv
module gfx_param_seq
    import gfx_cmd_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          busy,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [7:0]    rd_a,
    output logic [7:0]    rd_b,
    output logic [3:0]    key,
    output logic          launch,
    output launch_t       launch_info,
    output logic          idx_rst
);

    seq_state_e    st_q;
    logic [7:0]    cmd_q;
    logic [AW-1:0] in_idx_q;
    logic [AW-1:0] in_cnt_q;
    logic          pend_ovl_q, pend_rev_q;
    logic [7:0]    len_ovl_q, len_rev_q;
    logic [7:0]    key_q;
    logic [31:0]   opnd_q;
    logic [7:0]    pbuf [DEPTH];

    logic          acc, last, zero_cmd, len_phase, len_zero;
    logic [31:0]   opnd_next;

    always_comb begin
        acc       = wr_en && !busy;
        last      = (st_q == SQ_PARAM) &&
                    (({1'b0, in_idx_q} + 1'b1) == {1'b0, in_cnt_q});
        zero_cmd  = (st_q == SQ_CMD) && (param_count(wr_data) == '0);
        len_phase = ((cmd_q == OP_OVL) && !pend_ovl_q) ||
                    ((cmd_q == OP_REV) && !pend_rev_q);
        len_zero  = (wr_data == 8'h00);
        opnd_next = {wr_data, opnd_q[31:8]};
        idx_rst   = acc && (last || zero_cmd);
        launch    = acc && last &&
                    (((cmd_q == OP_OVL) && pend_ovl_q) ||
                     ((cmd_q == OP_REV) && pend_rev_q) ||
                     (cmd_q == OP_MUL));
        launch_info.opnd = opnd_next;
        if (cmd_q == OP_OVL) begin
            launch_info.kind = EX_OVERLAY;
            launch_info.len  = AW'(len_ovl_q);
        end else if (cmd_q == OP_REV) begin
            launch_info.kind = EX_REVERSE;
            launch_info.len  = AW'(len_rev_q);
        end else begin
            launch_info.kind = EX_PRODUCT;
            launch_info.len  = AW'(4);
        end
        rd_a = pbuf[rd_addr_a];
        rd_b = pbuf[rd_addr_b];
        key  = key_q[3:0];
    end

    always_ff @(posedge clk) begin
        if (acc && st_q == SQ_PARAM)
            pbuf[in_idx_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= SQ_CMD;
            cmd_q      <= 8'h00;
            in_idx_q   <= '0;
            in_cnt_q   <= '0;
            pend_ovl_q <= 1'b0;
            pend_rev_q <= 1'b0;
            len_ovl_q  <= 8'h00;
            len_rev_q  <= 8'h00;
            key_q      <= 8'h00;
            opnd_q     <= '0;
        end else if (acc) begin
            if (st_q == SQ_CMD) begin
                cmd_q    <= wr_data;
                in_idx_q <= '0;
                in_cnt_q <= param_count(wr_data);
                st_q     <= zero_cmd ? SQ_CMD : SQ_PARAM;
            end else begin
                opnd_q   <= opnd_next;
                in_idx_q <= in_idx_q + 1'b1;
                if (last) begin
                    st_q <= SQ_CMD;
                    case (cmd_q)
                        OP_KEY: key_q <= wr_data;
                        OP_OVL: begin
                            if (len_phase) begin
                                len_ovl_q <= wr_data;
                                if (!len_zero) begin
                                    pend_ovl_q <= 1'b1;
                                    in_idx_q   <= '0;
                                    in_cnt_q   <= AW'({wr_data, 1'b0});
                                    st_q       <= SQ_PARAM;
                                end
                            end else begin
                                pend_ovl_q <= 1'b0;
                            end
                        end
                        OP_REV: begin
                            if (len_phase) begin
                                len_rev_q <= wr_data;
                                if (!len_zero) begin
                                    pend_rev_q <= 1'b1;
                                    in_idx_q   <= '0;
                                    in_cnt_q   <= AW'(wr_data);
                                    st_q       <= SQ_PARAM;
                                end
                            end else begin
                                pend_rev_q <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R2: in parameter mode the index never reaches the expected count
    p_param_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_PARAM) |-> (in_idx_q < in_cnt_q));

    // R6: a zero length byte returns to opcode wait with no flag left set
    p_zero_len_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && last && len_phase && len_zero) |=>
            (st_q == SQ_CMD && !pend_ovl_q && !pend_rev_q));

    // R9: no byte is taken while an operation runs
    p_write_dropped_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> ($stable(st_q) && $stable(in_idx_q) && $stable(key_q)));

endmodule

// File: rtl/gfx_exec_unit.sv
module gfx_exec_unit
    import gfx_cmd_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  launch_t       launch_info,
    input  logic [3:0]    key,
    output logic [AW-1:0] addr_a,
    output logic [AW-1:0] addr_b,
    input  logic [7:0]    dat_a,
    input  logic [7:0]    dat_b,
    output logic          busy,
    output logic          ob_we,
    output logic [AW-1:0] ob_addr,
    output logic [7:0]    ob_data
);

    logic          busy_q;
    exec_kind_e    kind_q;
    logic [AW-1:0] len_q;
    logic [AW-1:0] k_q;
    logic [31:0]   prod_q;

    always_comb begin
        addr_a = (kind_q == EX_REVERSE) ? (len_q - 1'b1 - k_q) : k_q;
        addr_b = len_q + k_q;
        case (kind_q)
            EX_OVERLAY: ob_data = key_merge(dat_a, dat_b, key);
            EX_REVERSE: ob_data = nib_swap(dat_a);
            default:    ob_data = 8'(prod_q >> {k_q[1:0], 3'b000});
        endcase
        ob_we   = busy_q;
        ob_addr = k_q;
        busy    = busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            kind_q <= EX_OVERLAY;
            len_q  <= '0;
            k_q    <= '0;
            prod_q <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            kind_q <= launch_info.kind;
            len_q  <= launch_info.len;
            k_q    <= '0;
            prod_q <= launch_info.opnd[15:0] * launch_info.opnd[31:16];
        end else if (busy_q) begin
            k_q <= k_q + 1'b1;
            if (k_q == len_q - 1'b1)
                busy_q <= 1'b0;
        end
    end

    // R9: a new operation only starts from idle
    p_launch_idle_r9: assert property (@(posedge clk) disable iff (rst)
        launch |-> !busy_q);

    // R9: busy lasts exactly one cycle per result byte
    p_busy_span_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_q && (k_q == len_q - 1'b1)) |=> !busy_q);

    // R4 R5: an operation never runs with an empty result
    p_nonzero_len_r4: assert property (@(posedge clk) disable iff (rst)
        launch |-> (launch_info.len != '0));

endmodule

// File: rtl/gfx_out_port.sv
module gfx_out_port
    import gfx_cmd_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          busy,
    input  logic          launch,
    input  logic [AW-1:0] launch_len,
    input  logic          idx_rst,
    input  logic          ob_we,
    input  logic [AW-1:0] ob_addr,
    input  logic [7:0]    ob_data,
    output logic [7:0]    rd_data
);

    logic [7:0]    obuf [DEPTH];
    logic [AW-1:0] cnt_q;
    logic [AW-1:0] idx_q;
    logic          avail, take;

    always_comb begin
        avail   = !busy && (cnt_q != '0);
        take    = rd_en && avail;
        rd_data = avail ? obuf[idx_q] : 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (ob_we)
            obuf[ob_addr] <= ob_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            if (launch)
                cnt_q <= launch_len;
            else if (take && (idx_q + 1'b1 == cnt_q))
                cnt_q <= '0;
            if (idx_rst)
                idx_q <= '0;
            else if (take)
                idx_q <= idx_q + 1'b1;
        end
    end

    // R9: reads during an operation return the idle value
    p_busy_reads_ff_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rd_data == 8'hFF));

    // R9: the read position holds while busy
    p_idx_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !idx_rst) |=> $stable(idx_q));

    // R10: a completed phase rewinds the read position
    p_idx_rewind_r10: assert property (@(posedge clk) disable iff (rst)
        idx_rst |=> (idx_q == '0));

endmodule

// File: rtl/gfx_cmd_engine.sv
module gfx_cmd_engine
    import gfx_cmd_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       busy
);

    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] addr_a, addr_b, ob_addr;
    logic [7:0]    dat_a, dat_b, ob_data;
    logic [3:0]    key;
    logic          launch, idx_rst, ob_we, busy_int;
    launch_t       launch_info;

    gfx_param_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .busy(busy_int),
        .rd_addr_a(addr_a), .rd_addr_b(addr_b), .rd_a(dat_a), .rd_b(dat_b),
        .key(key), .launch(launch), .launch_info(launch_info), .idx_rst(idx_rst)
    );

    gfx_exec_unit #(.DEPTH(DEPTH)) u_exec (
        .clk(clk), .rst(rst), .launch(launch), .launch_info(launch_info), .key(key),
        .addr_a(addr_a), .addr_b(addr_b), .dat_a(dat_a), .dat_b(dat_b),
        .busy(busy_int), .ob_we(ob_we), .ob_addr(ob_addr), .ob_data(ob_data)
    );

    gfx_out_port #(.DEPTH(DEPTH)) u_out (
        .clk(clk), .rst(rst), .rd_en(rd_en), .busy(busy_int), .launch(launch),
        .launch_len(launch_info.len), .idx_rst(idx_rst), .ob_we(ob_we),
        .ob_addr(ob_addr), .ob_data(ob_data), .rd_data(rd_data)
    );

    assign busy = busy_int;

endmodule

// File: tb/test_gfx_cmd_engine.sv
`timescale 1ns/1ps
module test_gfx_cmd_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    gfx_cmd_engine i_gfx_cmd_engine (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compares each consumed read with the scoreboard head
    always @(negedge clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard empty R8", rd_data, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    task automatic wr(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic mul(input logic [15:0] a, input logic [15:0] b);
        wr(8'h09); wr(a[7:0]); wr(a[15:8]); wr(b[7:0]); wr(b[15:8]);
    endtask

    function automatic logic [7:0] ovl(input logic [7:0] a, input logic [7:0] b,
                                       input logic [3:0] k);
        logic [7:0] r;
        r[7:4] = (b[7:4] == k) ? a[7:4] : b[7:4];
        r[3:0] = (b[3:0] == k) ? a[3:0] : b[3:0];
        return r;
    endfunction

    task automatic report();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R9: actual hung expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] a3[3], b3[3], rv[4];
        logic [31:0] p;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(rd_data == 8'hFF, "R1 idle read value", rd_data, 8'hFF);
        rd(8'hFF, "R8 read with nothing pending");

        // R1 key is 0 after reset: overlay L=2
        wr(8'h05); wr(8'h02);
        wr(8'h3C); wr(8'h81); wr(8'h00); wr(8'h70);
        check(busy == 1'b1, "R9 busy after launch", busy, 1);
        rd(8'hFF, "R9 read while busy");
        wait_idle();
        rd(8'h3C, "R1 key zero byte0");
        rd(8'h71, "R1 key zero byte1");
        rd(8'hFF, "R8 drained");

        // R3 key from low nibble, R4 overlay L=3
        wr(8'h03); wr(8'hA5);
        a3 = '{8'h12, 8'h34, 8'hAB};
        b3 = '{8'h55, 8'h5F, 8'hC5};
        wr(8'h05); wr(8'h03);
        foreach (a3[i]) wr(a3[i]);
        foreach (b3[i]) wr(b3[i]);
        wait_idle();
        foreach (a3[i]) rd(ovl(a3[i], b3[i], 4'h5), "R3 R4 overlay byte");
        rd(8'hFF, "R8 overlay drained");

        // R5 reverse L=4, R9 write while busy dropped
        rv = '{8'h12, 8'h34, 8'h56, 8'h78};
        wr(8'h06); wr(8'h04);
        foreach (rv[i]) wr(rv[i]);
        wr(8'h09);
        wait_idle();
        for (int i = 0; i < 4; i++)
            rd({rv[3-i][3:0], rv[3-i][7:4]}, "R5 reverse byte");
        rd(8'hFF, "R8 reverse drained");

        // R7 multiply, R9 (stray opcode dropped), R10 rewind
        mul(16'h1234, 16'h5678);
        wait_idle();
        p = 32'h1234 * 32'h5678;
        rd(p[7:0], "R7 product byte0");
        rd(p[15:8], "R7 product byte1");
        wr(8'h03); wr(8'h05);
        for (int i = 0; i < 4; i++)
            rd(8'(p >> (8*i)), "R10 product reread");
        rd(8'hFF, "R8 product drained");

        // R6 zero lengths
        wr(8'h06); wr(8'h00);
        wr(8'h05); wr(8'h00);
        check(busy == 1'b0, "R6 no launch on zero length", busy, 0);
        rd(8'hFF, "R6 nothing pending");
        mul(16'hFFFF, 16'hFFFF);
        wait_idle();
        p = 32'hFFFF * 32'hFFFF;
        for (int i = 0; i < 4; i++)
            rd(8'(p >> (8*i)), "R6 R7 max product");
        rd(8'hFF, "R8 max drained");

        // R2 parameter counts of the other opcodes
        wr(8'h0D); wr(8'h11); wr(8'h22);
        wr(8'h0F); wr(8'h07); wr(8'h08); wr(8'h42);
        wr(8'h01);
        for (int i = 0; i < 32; i++) wr(8'(i * 7));
        rd(8'hFF, "R2 no output from skipped opcodes");
        mul(16'h0003, 16'h0005);
        wait_idle();
        rd(8'h0F, "R2 aligned product byte0");
        rd(8'h00, "R2 aligned product byte1");
        rd(8'h00, "R2 aligned product byte2");
        rd(8'h00, "R2 aligned product byte3");
        rd(8'hFF, "R2 aligned drained");

        @(posedge clk); #1;
        check(exp_q.size() == 0, "R8 scoreboard empty at end", exp_q.size(), 0);
        done = 1'b1;
        report();
        $finish;
    end

endmodule